// File: doc/BRIEF.md
# Segmented physical address generator

This block turns a segment-relative memory reference into a flat physical address. It keeps four segment base registers, for code, data, string destination (extra) and stack. For each request it picks one of them from the kind of access being made and one offset from seven candidate sources: program counter, base register, source index, destination index, stack pointer, frame pointer or an immediate operand. The physical address is the selected base moved up by a fixed number of bit positions plus the offset. The sum is truncated to the address width, so any carry past the top bit is lost.

The segment registers are loaded through a simple write port. The address and its valid flag come out of registers one clock after the request. Upstream logic that has already decoded the addressing mode drives the request, and the bus side takes the registered address. Segment override, protection and the bus cycle itself are left to other blocks.

With the default parameters, a 16-bit base is shifted by 4 positions and added to a 16-bit offset, which gives a 20-bit address. The offset width must not exceed SEG_W + SHIFT.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first request, `pa_valid` is 0 and `pa_out` is 0. All four segment registers reset to 0, so a request with a zero offset then yields address 0.
- R2: A request sampled at a rising edge gives, after that edge, `pa_out` = (segment << SHIFT) + offset taken modulo 2^PA_W, with PA_W = SEG_W + SHIFT. The low SHIFT bits of the address equal those of the offset.
- R3: A sum that carries past bit PA_W-1 wraps, and the carry is dropped. With base FFFFh and offset 0010h the address is 00000h. With base FFFFh and offset FFFFh it is 0FFEFh.
- R4: `req_kind` selects the segment: 0 = code fetch → code segment, 1 = data → data segment, 2 = string destination → extra segment, 3 = stack → stack segment.
- R5: `ofs_sel` selects the offset: 0 = `pc_ofs`, 1 = `base_ofs`, 2 = `srcidx_ofs`, 3 = `dstidx_ofs`, 4 = `stkptr_ofs`, 5 = `frmptr_ofs`, 6 = `imm_ofs`. Code 7 also selects `imm_ofs`.
- R6: A write on `seg_wr_en` with `seg_wr_sel` using the same 0..3 numbering as R4 lands at the clock edge. A request sampled at that same edge still uses the old value, and requests from the next edge onward use the new value.
- R7: `pa_valid` equals `req_valid` delayed by one clock. When no request was sampled, `pa_out` keeps its previous value.
- R8: A write to one segment register leaves the other three unchanged.
- R9: Base 1005h with offset 5555h gives physical address 155A5h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment register to write (0 code, 1 data, 2 extra, 3 stack) |
| seg_wr_data | input | SEG_W | Value to write |
| req_valid | input | 1 | Address request strobe |
| req_kind | input | 2 | Access kind, picks the segment |
| ofs_sel | input | 3 | Offset source select |
| pc_ofs | input | OFS_W | Program counter offset |
| base_ofs | input | OFS_W | Base register offset |
| srcidx_ofs | input | OFS_W | Source index offset |
| dstidx_ofs | input | OFS_W | Destination index offset |
| stkptr_ofs | input | OFS_W | Stack pointer offset |
| frmptr_ofs | input | OFS_W | Frame pointer offset |
| imm_ofs | input | OFS_W | Immediate offset operand |
| pa_out | output | SEG_W+SHIFT | Registered physical address |
| pa_valid | output | 1 | Registered request valid |

## Verification
The bench builds the block with its default widths: 16-bit bases, 16-bit offsets and a 4-bit shift. With these widths the published example value and a carry out of bit 19 can both be checked directly. Every access kind is swept against every offset select code, including the spare code. A grid of base and offset values near 0000h, 0FFFh, 8000h and FFFFh is run under each segment, which drives carries through the nibble boundary and off the top of the address. The write-versus-request ordering is checked on the exact edge where both happen together.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  localparam int NUM_SEG   = 4;
  localparam int SEG_IDX_W = $clog2(NUM_SEG);

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'd0,
    ACC_DATA   = 2'd1,
    ACC_STRDST = 2'd2,
    ACC_STACK  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_EXTRA = 2'd2,
    SEG_STACK = 2'd3
  } seg_idx_e;

  typedef enum logic [2:0] {
    OFS_PC      = 3'd0,
    OFS_BASE    = 3'd1,
    OFS_SRCIDX  = 3'd2,
    OFS_DSTIDX  = 3'd3,
    OFS_STKPTR  = 3'd4,
    OFS_FRMPTR  = 3'd5,
    OFS_IMM     = 3'd6,
    OFS_SPARE   = 3'd7
  } ofs_src_e;

  // Segment chosen by the kind of access
  function automatic seg_idx_e seg_for_kind(acc_kind_e kind);
    seg_idx_e idx;
    case (kind)
      ACC_FETCH:  idx = SEG_CODE;
      ACC_DATA:   idx = SEG_DATA;
      ACC_STRDST: idx = SEG_EXTRA;
      default:    idx = SEG_STACK;
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/seg_bank.sv
module seg_bank
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEG_IDX_W-1:0] wr_sel,
  input  logic [SEG_W-1:0]     wr_data,
  input  logic [SEG_IDX_W-1:0] rd_sel,
  output logic [SEG_W-1:0]     rd_data
);

  logic [SEG_W-1:0] seg_q [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic             ld_en;
    logic [SEG_W-1:0] seg_d;

    always_comb begin
      ld_en = wr_en && (wr_sel == SEG_IDX_W'(g));
      seg_d = ld_en ? wr_data : seg_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg_q[g] <= '0;
      end else if (ld_en) begin
        seg_q[g] <= seg_d;
      end
    end
  end

  // Read returns the stored value; a write lands only at the edge
  assign rd_data = seg_q[rd_sel];

endmodule

// File: rtl/seg_ofs_mux.sv
module seg_ofs_mux
  import seg_addr_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  ofs_src_e         sel,
  input  logic [OFS_W-1:0] pc_ofs,
  input  logic [OFS_W-1:0] base_ofs,
  input  logic [OFS_W-1:0] srcidx_ofs,
  input  logic [OFS_W-1:0] dstidx_ofs,
  input  logic [OFS_W-1:0] stkptr_ofs,
  input  logic [OFS_W-1:0] frmptr_ofs,
  input  logic [OFS_W-1:0] imm_ofs,
  output logic [OFS_W-1:0] ofs
);

  always_comb begin
    case (sel)
      OFS_PC:     ofs = pc_ofs;
      OFS_BASE:   ofs = base_ofs;
      OFS_SRCIDX: ofs = srcidx_ofs;
      OFS_DSTIDX: ofs = dstidx_ofs;
      OFS_STKPTR: ofs = stkptr_ofs;
      OFS_FRMPTR: ofs = frmptr_ofs;
      default:    ofs = imm_ofs;
    endcase
  end

endmodule

// File: rtl/seg_pa_adder.sv
module seg_pa_adder #(
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFS_W-1:0] ofs,
  output logic [PA_W-1:0]  pa
);

  logic [PA_W-1:0] seg_ext;
  logic [PA_W-1:0] ofs_ext;

  always_comb begin
    seg_ext = {seg, {SHIFT{1'b0}}};
    ofs_ext = PA_W'(ofs);
    // Truncating add: carry beyond the top address bit is dropped
    pa      = seg_ext + ofs_ext;
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_wr_en,
  input  logic [1:0]       seg_wr_sel,
  input  logic [SEG_W-1:0] seg_wr_data,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [2:0]       ofs_sel,
  input  logic [OFS_W-1:0] pc_ofs,
  input  logic [OFS_W-1:0] base_ofs,
  input  logic [OFS_W-1:0] srcidx_ofs,
  input  logic [OFS_W-1:0] dstidx_ofs,
  input  logic [OFS_W-1:0] stkptr_ofs,
  input  logic [OFS_W-1:0] frmptr_ofs,
  input  logic [OFS_W-1:0] imm_ofs,
  output logic [PA_W-1:0]  pa_out,
  output logic             pa_valid
);

  logic             rst_n_sync;
  seg_idx_e         rd_idx;
  logic [SEG_W-1:0] seg_val;
  logic [OFS_W-1:0] ofs_val;
  logic [PA_W-1:0]  pa_sum;
  logic [PA_W-1:0]  pa_d;
  logic [PA_W-1:0]  pa_q;
  logic             vld_q;

  seg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign rd_idx = seg_for_kind(acc_kind_e'(req_kind));

  seg_bank #(.SEG_W(SEG_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (seg_wr_en),
    .wr_sel  (seg_wr_sel),
    .wr_data (seg_wr_data),
    .rd_sel  (rd_idx),
    .rd_data (seg_val)
  );

  seg_ofs_mux #(.OFS_W(OFS_W)) u_mux (
    .sel        (ofs_src_e'(ofs_sel)),
    .pc_ofs     (pc_ofs),
    .base_ofs   (base_ofs),
    .srcidx_ofs (srcidx_ofs),
    .dstidx_ofs (dstidx_ofs),
    .stkptr_ofs (stkptr_ofs),
    .frmptr_ofs (frmptr_ofs),
    .imm_ofs    (imm_ofs),
    .ofs        (ofs_val)
  );

  seg_pa_adder #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT)) u_add (
    .seg (seg_val),
    .ofs (ofs_val),
    .pa  (pa_sum)
  );

  always_comb begin
    pa_d = req_valid ? pa_sum : pa_q;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      pa_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= req_valid;
      if (req_valid) begin
        pa_q <= pa_d;
      end
    end
  end

  assign pa_out   = pa_q;
  assign pa_valid = vld_q;

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seg_wr_en,
  input logic [1:0]       seg_wr_sel,
  input logic [SEG_W-1:0] seg_wr_data,
  input logic             req_valid,
  input logic [1:0]       req_kind,
  input logic [2:0]       ofs_sel,
  input logic [OFS_W-1:0] pc_ofs,
  input logic [OFS_W-1:0] base_ofs,
  input logic [OFS_W-1:0] srcidx_ofs,
  input logic [OFS_W-1:0] dstidx_ofs,
  input logic [OFS_W-1:0] stkptr_ofs,
  input logic [OFS_W-1:0] frmptr_ofs,
  input logic [OFS_W-1:0] imm_ofs,
  input logic [PA_W-1:0]  pa_out,
  input logic             pa_valid
);

  logic             armed;
  logic [SEG_W-1:0] mdl_seg [NUM_SEG];
  logic [OFS_W-1:0] pick_ofs;
  logic [PA_W-1:0]  exp_pa;
  logic [PA_W-1:0]  exp_q;
  logic [OFS_W-1:0] ofs_q;

  always_comb begin
    case (ofs_sel)
      3'd0:    pick_ofs = pc_ofs;
      3'd1:    pick_ofs = base_ofs;
      3'd2:    pick_ofs = srcidx_ofs;
      3'd3:    pick_ofs = dstidx_ofs;
      3'd4:    pick_ofs = stkptr_ofs;
      3'd5:    pick_ofs = frmptr_ofs;
      default: pick_ofs = imm_ofs;
    endcase
    exp_pa = PA_W'({mdl_seg[req_kind], {SHIFT{1'b0}}}) + PA_W'(pick_ofs);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      exp_q <= '0;
      ofs_q <= '0;
      for (int i = 0; i < NUM_SEG; i++) mdl_seg[i] <= '0;
    end else begin
      armed <= 1'b1;
      if (req_valid) begin
        exp_q <= exp_pa;
        ofs_q <= pick_ofs;
      end
      if (seg_wr_en) mdl_seg[seg_wr_sel] <= seg_wr_data;
    end
  end

  // R1: quiet outputs while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!pa_valid && pa_out == '0)
        else $error("outputs active during reset");
    end
  end

  // R7: valid is the request delayed by one clock
  assert_valid_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> pa_valid == $past(req_valid));

  // R7: address holds when no request was taken
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(req_valid) |-> pa_out == $past(pa_out));

  // R2, R3, R4, R5, R6: address matches the shadow segment model
  assert_model_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && pa_valid |-> pa_out == exp_q);

  // R2: low bits of the address come straight from the offset
  assert_low_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && pa_valid |-> pa_out[SHIFT-1:0] == ofs_q[SHIFT-1:0]);

endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .seg_wr_en   (seg_wr_en),
  .seg_wr_sel  (seg_wr_sel),
  .seg_wr_data (seg_wr_data),
  .req_valid   (req_valid),
  .req_kind    (req_kind),
  .ofs_sel     (ofs_sel),
  .pc_ofs      (pc_ofs),
  .base_ofs    (base_ofs),
  .srcidx_ofs  (srcidx_ofs),
  .dstidx_ofs  (dstidx_ofs),
  .stkptr_ofs  (stkptr_ofs),
  .frmptr_ofs  (frmptr_ofs),
  .imm_ofs     (imm_ofs),
  .pa_out      (pa_out),
  .pa_valid    (pa_valid)
);

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;

  localparam int SEG_W = 16;
  localparam int OFS_W = 16;
  localparam int SHIFT = 4;
  localparam int PA_W  = SEG_W + SHIFT;

  logic             clk;
  logic             rst_n;
  logic             seg_wr_en;
  logic [1:0]       seg_wr_sel;
  logic [SEG_W-1:0] seg_wr_data;
  logic             req_valid;
  logic [1:0]       req_kind;
  logic [2:0]       ofs_sel;
  logic [OFS_W-1:0] pc_ofs, base_ofs, srcidx_ofs, dstidx_ofs;
  logic [OFS_W-1:0] stkptr_ofs, frmptr_ofs, imm_ofs;
  logic [PA_W-1:0]  pa_out;
  logic             pa_valid;

  int  checks;
  int  fails;
  bit  done;
  logic [15:0] shadow [4];
  logic [15:0] pat [9];

  seg_addr_gen #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT)) uut (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
    .req_valid(req_valid), .req_kind(req_kind), .ofs_sel(ofs_sel),
    .pc_ofs(pc_ofs), .base_ofs(base_ofs), .srcidx_ofs(srcidx_ofs),
    .dstidx_ofs(dstidx_ofs), .stkptr_ofs(stkptr_ofs), .frmptr_ofs(frmptr_ofs),
    .imm_ofs(imm_ofs), .pa_out(pa_out), .pa_valid(pa_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pa(logic [15:0] s, logic [15:0] o);
    return (({16'b0, s} << 4) + {16'b0, o}) & 32'h000F_FFFF;
  endfunction

  task automatic set_offsets(logic [2:0] sel, logic [15:0] v);
    logic [15:0] other;
    other = v ^ 16'hA5A5;
    pc_ofs = other; base_ofs = other; srcidx_ofs = other; dstidx_ofs = other;
    stkptr_ofs = other; frmptr_ofs = other; imm_ofs = other;
    case (sel)
      3'd0: pc_ofs = v;
      3'd1: base_ofs = v;
      3'd2: srcidx_ofs = v;
      3'd3: dstidx_ofs = v;
      3'd4: stkptr_ofs = v;
      3'd5: frmptr_ofs = v;
      default: imm_ofs = v;
    endcase
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic write_seg(int idx, logic [15:0] v);
    seg_wr_en = 1'b1; seg_wr_sel = 2'(idx); seg_wr_data = v;
    @(negedge clk);
    seg_wr_en = 1'b0;
    shadow[idx] = v;
  endtask

  task automatic request(string tag, int kind, logic [2:0] sel, logic [15:0] v);
    set_offsets(sel, v);
    req_kind = 2'(kind); ofs_sel = sel; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, {31'b0, pa_valid}, 32'd1);
    chk(tag, {12'b0, pa_out}, exp_pa(shadow[kind], v));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    for (int i = 0; i < 4; i++) shadow[i] = 16'h0000;
    pat = '{16'h0000, 16'h0001, 16'h000F, 16'h0FFF, 16'h1000,
            16'h7FFF, 16'h8000, 16'hFFF0, 16'hFFFF};
    rst_n = 1'b0; seg_wr_en = 1'b0; seg_wr_sel = 2'd0; seg_wr_data = '0;
    req_valid = 1'b0; req_kind = 2'd0; ofs_sel = 3'd0;
    set_offsets(3'd0, 16'h0000);

    // R1: reset state, then after release
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'b0, pa_valid}, 32'd0);
    chk("R1 addr in reset", {12'b0, pa_out}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 valid after release", {31'b0, pa_valid}, 32'd0);
    chk("R1 addr after release", {12'b0, pa_out}, 32'd0);
    for (int k = 0; k < 4; k++) request("R1 zero segment", k, 3'd6, 16'h0000);

    // R9: worked example
    write_seg(1, 16'h1005);
    request("R9", 1, 3'd6, 16'h5555);
    chk("R9 literal", {12'b0, pa_out}, 32'h155A5);

    // R4: each access kind reads its own segment
    write_seg(0, 16'h1234);
    write_seg(2, 16'h2468);
    write_seg(3, 16'h3579);
    for (int k = 0; k < 4; k++) request("R4 kind map", k, 3'd1, 16'h0010);

    // R5: every offset select code, including the spare one
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 4; k++)
        request("R5 offset select", k, 3'(s), 16'h0100 + 16'(s) * 16'h1111);

    // R3: wrap past the top address bit
    write_seg(0, 16'hFFFF);
    request("R3 wrap", 0, 3'd0, 16'h0010);
    chk("R3 wrap literal", {12'b0, pa_out}, 32'h00000);
    request("R3 wrap", 0, 3'd4, 16'hFFFF);
    chk("R3 max literal", {12'b0, pa_out}, 32'h0FFEF);

    // R2: grid of bases and offsets under every segment
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 9; a++) begin
        write_seg(k, pat[a]);
        for (int b = 0; b < 9; b++)
          request("R2 sweep", k, 3'((a + b) % 8), pat[b]);
      end

    // R6: write and request on the same edge
    write_seg(0, 16'h1111); write_seg(1, 16'h2222);
    write_seg(2, 16'h3333); write_seg(3, 16'h4444);
    seg_wr_en = 1'b1; seg_wr_sel = 2'd2; seg_wr_data = 16'h0ABC;
    set_offsets(3'd3, 16'h0001);
    req_kind = 2'd2; ofs_sel = 3'd3; req_valid = 1'b1;
    @(negedge clk);
    seg_wr_en = 1'b0; req_valid = 1'b0;
    chk("R6 same edge uses old", {12'b0, pa_out}, exp_pa(16'h3333, 16'h0001));
    shadow[2] = 16'h0ABC;
    request("R6 next uses new", 2, 3'd3, 16'h0001);
    chk("R6 new literal", {12'b0, pa_out}, 32'h0ABC1);

    // R8: the other segments kept their values
    request("R8 code kept", 0, 3'd6, 16'h0002);
    chk("R8 code literal", {12'b0, pa_out}, 32'h11112);
    request("R8 data kept", 1, 3'd6, 16'h0002);
    chk("R8 data literal", {12'b0, pa_out}, 32'h22222);
    request("R8 stack kept", 3, 3'd6, 16'h0002);
    chk("R8 stack literal", {12'b0, pa_out}, 32'h44442);

    // R7: no request -> valid low, address held
    request("R7 setup", 3, 3'd5, 16'h0777);
    set_offsets(3'd6, 16'hBEEF);
    req_kind = 2'd0; ofs_sel = 3'd6;
    @(negedge clk);
    chk("R7 valid low", {31'b0, pa_valid}, 32'd0);
    chk("R7 addr held", {12'b0, pa_out}, exp_pa(16'h4444, 16'h0777));
    @(negedge clk);
    chk("R7 addr still held", {12'b0, pa_out}, exp_pa(16'h4444, 16'h0777));

    // R7: back-to-back requests keep valid high
    request("R7 back to back", 1, 3'd2, 16'h0100);
    request("R7 back to back", 2, 3'd3, 16'h0200);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule